// File: doc/BRIEF.md
# Triple Prescaled Interval Timer Unit

Three down-counting timers share the block clock, which serves as the base oscillator. Each timer has its own fixed prescaler: timer 0 divides by 10, and timers 1 and 2 divide by 1000. A host chooses a timer through a select port and then loads or reads its count through a 16-bit data port. Timers 0 and 1 hold 16-bit divisors. Timer 2 holds a 24-bit divisor, so it takes two select indices: index 2 reaches its lower 16 bits and index 3 reaches its upper 8 bits.

A 6-bit mode word gives each timer one of four behaviours: interrupt on terminal count, rate generator, software-triggered strobe, or hardware-triggered strobe. A per-timer gate bit allows counting. Timer 2 has two further settings. Its clock source can be the prescaled oscillator, timer 1's expiry pulses, end-of-conversion events or end-of-scan events. Its role can be timer, event counter or watchdog. When timer 2 expires it sets a sticky flag, and any read of the select register clears that flag. The select write also carries four digital-output levels, which the block holds.

Top module: `prescaled_timer_unit`

## Requirements
- R1: Each prescaler counts from the release of reset. Timer 0 gets one count tick every 10 clocks. Timers 1 and 2 get one every 1000 clocks, as set by the parameters PRE0, PRE1 and PRE2.
- R2: A select write stores `sel_idx_i`. A data write with index 0 or 1 loads that timer's divisor. Index 2 writes the lower 16 bits of timer 2's divisor, and index 3 writes its upper 8 bits from data bits 7:0. `dat_rdata_o` shows the current count of the selected timer: the full count for index 0 or 1, count bits 15:0 for index 2, and count bits 23:16 zero-extended for index 3.
- R3: Timer i takes its mode from `tmode_wdata_i[2i+1:2i]`: 0 is terminal-count interrupt, 1 is rate generator, 2 is software strobe and 3 is hardware strobe. When a mode write changes a timer's field, that timer goes idle: count 0 and output low. All state is 0 after reset.
- R4: A timer's count changes on a prescaler tick only while its gate bit (`gate_wdata_i[i]`, stored by `gate_we_i`) is 1. With the gate at 0 and no load, the count holds.
- R5: A divisor of 0 or 1 is used as 2.
- R6: In mode 0, a divisor load starts a countdown. For timers 0 and 1 the load is the index write; for timer 2 it is the index-3 write. The output goes high in the cycle after the count reaches 0. It stays high until the next load or mode change.
- R7: In mode 1, the first gated tick after idle loads the divisor. From then on, each tick that finds count 1 reloads the divisor and produces a one-cycle output pulse. A divisor written while counting takes effect at the next reload.
- R8: In mode 2, a divisor load starts one countdown. Expiry gives a one-cycle strobe, and the timer then stays idle at count 0.
- R9: In mode 3, a 0-to-1 change of the timer's gate bit starts a countdown from the stored divisor, and expiry gives a one-cycle strobe. A divisor write in this mode only stores the divisor.
- R10: Timer 2's source `cfg_src_i` selects 0 for the oscillator, 1 for timer 1 expiry pulses, 2 for `eoc_i` and 3 for `eos_i`. Its role `cfg_role_i` selects 0 for timer, 1 for counter and 2 for watchdog; code 3 acts as timer. The oscillator source goes through the prescaler unless the role is counter, in which case every clock ticks. Every other source ticks once per event. In watchdog role, a select read reloads a nonzero count.
- R11: `t2_flag_o` rises in the cycle after timer 2's expiry pulse. A select read (`sel_re_i`) clears it. If a set and a clear fall in the same cycle, the set wins.
- R12: `dout_o` takes `sel_dout_i` on each select write and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock and base oscillator |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Select register write strobe |
| sel_idx_i | input | 2 | Timer index (3 = timer 2 upper half) |
| sel_dout_i | input | 4 | Digital-output levels written with the select |
| sel_re_i | input | 1 | Select register read strobe |
| dat_we_i | input | 1 | Data port write strobe |
| dat_wdata_i | input | 16 | Divisor data |
| dat_rdata_o | output | 16 | Count of the selected timer |
| tmode_we_i | input | 1 | Mode word write strobe |
| tmode_wdata_i | input | 6 | Three 2-bit timer modes |
| gate_we_i | input | 1 | Gate write strobe |
| gate_wdata_i | input | 3 | Per-timer gate bits |
| cfg_we_i | input | 1 | Timer 2 configuration write strobe |
| cfg_src_i | input | 2 | Timer 2 clock source |
| cfg_role_i | input | 2 | Timer 2 role |
| eoc_i | input | 1 | End-of-conversion event |
| eos_i | input | 1 | End-of-scan event |
| tmr_out_o | output | 3 | Per-timer output (level in mode 0, pulse otherwise) |
| t2_flag_o | output | 1 | Timer 2 terminal-count flag |
| dout_o | output | 4 | Held digital-output levels |

## Verification
Timer 2's flag can be set by an expiry and cleared by a host select read in the same clock. The bench provokes this by running timer 2 as a rate-generating event counter on an end-of-conversion train, with a clearing read issued on every cycle of that train, so that expiries land on read cycles. A behavioural model lets the set win, and it is compared with the flag and every other output on each clock. A second overlap comes from watchdog kicks, which also clear the flag, issued while the countdown is still running.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  parameter int unsigned NUM_TMR = 3;
  parameter int unsigned DATA_W  = 16;

  typedef enum logic [1:0] {
    MODE_ITC       = 2'd0,
    MODE_RATE      = 2'd1,
    MODE_SW_STROBE = 2'd2,
    MODE_HW_STROBE = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    SRC_OSC = 2'd0,
    SRC_T1  = 2'd1,
    SRC_EOC = 2'd2,
    SRC_EOS = 2'd3
  } t2_src_e;

  typedef enum logic [1:0] {
    ROLE_TIMER   = 2'd0,
    ROLE_COUNTER = 2'd1,
    ROLE_WDOG    = 2'd2,
    ROLE_RSVD    = 2'd3
  } t2_role_e;
endpackage

// File: rtl/ptu_prescaler.sv
module ptu_prescaler #(
  parameter int unsigned DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  // DIV must be at least 2
  localparam int unsigned CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  p_tick_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ptu_counter.sv
module ptu_counter
  import ptu_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              gate_rise_i,
  input  tmr_mode_e         mode_i,
  input  logic              mode_chg_i,
  input  logic              wr_i,
  input  logic [1:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              kick_i,
  output logic [W-1:0]      cnt_o,
  output logic              evt_o,
  output logic              out_o
);
  localparam logic [W-1:0] MIN_DIV = W'(2);

  logic [W-1:0] div_q, div_nx, cnt_q, eff_q, eff_nx;
  logic         lvl_q, evt_q, ld_lo, load;

  assign ld_lo = wr_i && (idx_i == 2'(IDX));

  generate
    if (W > DATA_W) begin : g_wide
      logic ld_hi;
      assign ld_hi = wr_i && (idx_i == 2'(IDX + 1));
      assign load  = ld_hi;
      always_comb begin
        div_nx = div_q;
        if (ld_lo) div_nx[DATA_W-1:0] = wdata_i;
        if (ld_hi) div_nx[W-1:DATA_W] = wdata_i[W-DATA_W-1:0];
      end
    end else begin : g_narrow
      assign load = ld_lo;
      always_comb begin
        div_nx = div_q;
        if (ld_lo) div_nx = wdata_i[W-1:0];
      end
    end
  endgenerate

  assign eff_q  = (div_q  < MIN_DIV) ? MIN_DIV : div_q;
  assign eff_nx = (div_nx < MIN_DIV) ? MIN_DIV : div_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      div_q <= div_nx;
      evt_q <= 1'b0;
      if (mode_chg_i) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else if (load && (mode_i == MODE_ITC || mode_i == MODE_SW_STROBE)) begin
        cnt_q <= eff_nx;
        lvl_q <= 1'b0;
      end else if (mode_i == MODE_HW_STROBE && gate_rise_i) begin
        cnt_q <= eff_q;
      end else if (kick_i && cnt_q != '0) begin
        cnt_q <= eff_q;
      end else if (tick_i && gate_i) begin
        if (mode_i == MODE_RATE) begin
          if (cnt_q == '0) cnt_q <= eff_q;
          else if (cnt_q == W'(1)) begin
            cnt_q <= eff_q;
            evt_q <= 1'b1;
          end else cnt_q <= cnt_q - W'(1);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - W'(1);
          if (cnt_q == W'(1)) begin
            evt_q <= 1'b1;
            if (mode_i == MODE_ITC) lvl_q <= 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;
  assign out_o = (mode_i == MODE_ITC) ? lvl_q : evt_q;

  p_gate_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !load && !mode_chg_i && !gate_rise_i && !kick_i) |=> $stable(cnt_q));
  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !mode_chg_i && (mode_i == MODE_ITC || mode_i == MODE_SW_STROBE)) |=> cnt_q >= MIN_DIV);
  p_itc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ITC && lvl_q && !load && !mode_chg_i) |=> lvl_q);
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
  p_idle_on_chg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> (cnt_q == '0 && !lvl_q));
endmodule

// File: rtl/prescaled_timer_unit.sv
module prescaled_timer_unit
  import ptu_pkg::*;
#(
  parameter int unsigned PRE0    = 10,
  parameter int unsigned PRE1    = 1000,
  parameter int unsigned PRE2    = 1000,
  parameter int unsigned W_SHORT = 16,
  parameter int unsigned W_LONG  = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_we_i,
  input  logic [1:0]  sel_idx_i,
  input  logic [3:0]  sel_dout_i,
  input  logic        sel_re_i,
  input  logic        dat_we_i,
  input  logic [15:0] dat_wdata_i,
  output logic [15:0] dat_rdata_o,
  input  logic        tmode_we_i,
  input  logic [5:0]  tmode_wdata_i,
  input  logic        gate_we_i,
  input  logic [2:0]  gate_wdata_i,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_src_i,
  input  logic [1:0]  cfg_role_i,
  input  logic        eoc_i,
  input  logic        eos_i,
  output logic [2:0]  tmr_out_o,
  output logic        t2_flag_o,
  output logic [3:0]  dout_o
);
  localparam int unsigned NT = NUM_TMR;
  localparam int unsigned PRE_T [NT] = '{PRE0, PRE1, PRE2};

  logic [1:0]        idx_q;
  logic [3:0]        dout_q;
  logic [NT-1:0]     gate_q;
  tmr_mode_e         mode_q [NT];
  t2_src_e           src_q;
  t2_role_e          role_q;
  logic              flag_q;
  logic [NT-1:0]     pre_tick, tick, evt, rise, chg;
  logic [W_LONG-1:0] cnt_w [NT];
  logic              kick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      dout_q <= '0;
      gate_q <= '0;
      src_q  <= SRC_OSC;
      role_q <= ROLE_TIMER;
      flag_q <= 1'b0;
      for (int k = 0; k < NT; k++) mode_q[k] <= MODE_ITC;
    end else begin
      if (sel_we_i) begin
        idx_q  <= sel_idx_i;
        dout_q <= sel_dout_i;
      end
      if (gate_we_i) gate_q <= gate_wdata_i;
      if (tmode_we_i)
        for (int k = 0; k < NT; k++) mode_q[k] <= tmr_mode_e'(tmode_wdata_i[2*k +: 2]);
      if (cfg_we_i) begin
        src_q  <= t2_src_e'(cfg_src_i);
        role_q <= t2_role_e'(cfg_role_i);
      end
      if (evt[NT-1])     flag_q <= 1'b1;  // set beats clear
      else if (sel_re_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      rise[k] = gate_we_i && gate_wdata_i[k] && !gate_q[k];
      chg[k]  = tmode_we_i && (tmr_mode_e'(tmode_wdata_i[2*k +: 2]) != mode_q[k]);
    end
  end

  assign kick = sel_re_i && (role_q == ROLE_WDOG);

  always_comb begin
    tick = pre_tick;
    unique case (src_q)
      SRC_OSC: tick[NT-1] = (role_q == ROLE_COUNTER) ? 1'b1 : pre_tick[NT-1];
      SRC_T1:  tick[NT-1] = evt[1];
      SRC_EOC: tick[NT-1] = eoc_i;
      SRC_EOS: tick[NT-1] = eos_i;
      default: tick[NT-1] = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    localparam int unsigned W = (g == NT - 1) ? W_LONG : W_SHORT;
    logic [W-1:0] c;

    ptu_prescaler #(.DIV(PRE_T[g])) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (pre_tick[g])
    );

    ptu_counter #(.W(W), .IDX(g)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick[g]),
      .gate_i      (gate_q[g]),
      .gate_rise_i (rise[g]),
      .mode_i      (mode_q[g]),
      .mode_chg_i  (chg[g]),
      .wr_i        (dat_we_i),
      .idx_i       (idx_q),
      .wdata_i     (dat_wdata_i),
      .kick_i      ((g == NT - 1) ? kick : 1'b0),
      .cnt_o       (c),
      .evt_o       (evt[g]),
      .out_o       (tmr_out_o[g])
    );

    assign cnt_w[g] = W_LONG'(c);
  end

  always_comb begin
    unique case (idx_q)
      2'd0:    dat_rdata_o = cnt_w[0][15:0];
      2'd1:    dat_rdata_o = cnt_w[1][15:0];
      2'd2:    dat_rdata_o = cnt_w[2][15:0];
      default: dat_rdata_o = 16'(cnt_w[2][W_LONG-1:16]);
    endcase
  end

  assign t2_flag_o = flag_q;
  assign dout_o    = dout_q;

  p_flag_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[NT-1] |=> t2_flag_o);
  p_flag_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t2_flag_o && sel_re_i && !evt[NT-1]) |=> !t2_flag_o);
  p_dout_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(dout_o));
  p_idx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(idx_q));
endmodule

// File: tb/tb_prescaled_timer_unit.sv
module tb_prescaled_timer_unit;
  localparam int PRE [3] = '{10, 1000, 1000};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel_we = 0, sel_re = 0, dat_we = 0, tmode_we = 0, gate_we = 0, cfg_we = 0;
  logic [1:0]  sel_idx = 0, cfg_src = 0, cfg_role = 0;
  logic [3:0]  sel_dout = 0;
  logic [15:0] dat_wdata = 0;
  logic [5:0]  tmode_wdata = 0;
  logic [2:0]  gate_wdata = 0;
  logic        eoc = 0, eos = 0;
  logic [15:0] dat_rdata;
  logic [2:0]  tmr_out;
  logic        t2_flag;
  logic [3:0]  dout;

  int checks = 0, errors = 0;
  longint cyc = 0;

  always #4 clk = ~clk;

  prescaled_timer_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_we_i(sel_we), .sel_idx_i(sel_idx), .sel_dout_i(sel_dout), .sel_re_i(sel_re),
    .dat_we_i(dat_we), .dat_wdata_i(dat_wdata), .dat_rdata_o(dat_rdata),
    .tmode_we_i(tmode_we), .tmode_wdata_i(tmode_wdata),
    .gate_we_i(gate_we), .gate_wdata_i(gate_wdata),
    .cfg_we_i(cfg_we), .cfg_src_i(cfg_src), .cfg_role_i(cfg_role),
    .eoc_i(eoc), .eos_i(eos),
    .tmr_out_o(tmr_out), .t2_flag_o(t2_flag), .dout_o(dout)
  );

  // behavioural reference model
  int       m_pc [3], m_cnt [3], m_div [3];
  bit       m_lvl [3], m_evt [3], m_gate [3];
  bit [1:0] m_mode [3];
  int       m_idx, m_src, m_role;
  bit [3:0] m_dout;
  bit       m_flag;
  bit       t_tk [3], t_ev [3];
  int       t_nd [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_pc[i] = 0; m_cnt[i] = 0; m_div[i] = 0; m_lvl[i] = 0; m_evt[i] = 0;
        m_gate[i] = 0; m_mode[i] = 0;
      end
      m_idx = 0; m_src = 0; m_role = 0; m_dout = 0; m_flag = 0;
    end else begin
      for (int i = 0; i < 3; i++) t_tk[i] = (m_pc[i] == PRE[i] - 1);
      case (m_src)
        0: t_tk[2] = (m_role == 1) ? 1'b1 : (m_pc[2] == PRE[2] - 1);
        1: t_tk[2] = m_evt[1];
        2: t_tk[2] = eoc;
        default: t_tk[2] = eos;
      endcase
      for (int i = 0; i < 3; i++) begin
        bit lo, ld, rise, chg, kick;
        int eo, en;
        lo   = dat_we && (m_idx == i);
        ld   = (i == 2) ? (dat_we && m_idx == 3) : lo;
        rise = gate_we && gate_wdata[i] && !m_gate[i];
        chg  = tmode_we && (tmode_wdata[2*i +: 2] != m_mode[i]);
        kick = (i == 2) && sel_re && (m_role == 2);
        t_nd[i] = m_div[i];
        if (lo) t_nd[i] = (i == 2) ? ((t_nd[i] & 32'hFF0000) | int'(dat_wdata)) : int'(dat_wdata);
        if (i == 2 && ld) t_nd[i] = (t_nd[i] & 32'hFFFF) | (int'(dat_wdata & 16'hFF) << 16);
        eo = (m_div[i] < 2) ? 2 : m_div[i];
        en = (t_nd[i] < 2) ? 2 : t_nd[i];
        t_ev[i] = 0;
        if (chg) begin
          m_cnt[i] = 0; m_lvl[i] = 0;
        end else if (ld && (m_mode[i] == 0 || m_mode[i] == 2)) begin
          m_cnt[i] = en; m_lvl[i] = 0;
        end else if (m_mode[i] == 3 && rise) begin
          m_cnt[i] = eo;
        end else if (kick && m_cnt[i] != 0) begin
          m_cnt[i] = eo;
        end else if (t_tk[i] && m_gate[i]) begin
          if (m_mode[i] == 1) begin
            if (m_cnt[i] == 0) m_cnt[i] = eo;
            else if (m_cnt[i] == 1) begin m_cnt[i] = eo; t_ev[i] = 1; end
            else m_cnt[i] = m_cnt[i] - 1;
          end else if (m_cnt[i] != 0) begin
            if (m_cnt[i] == 1) begin t_ev[i] = 1; if (m_mode[i] == 0) m_lvl[i] = 1; end
            m_cnt[i] = m_cnt[i] - 1;
          end
        end
      end
      if (m_evt[2]) m_flag = 1;
      else if (sel_re) m_flag = 0;
      for (int i = 0; i < 3; i++) begin
        m_pc[i]  = (m_pc[i] == PRE[i] - 1) ? 0 : m_pc[i] + 1;
        m_div[i] = t_nd[i];
        m_evt[i] = t_ev[i];
      end
      if (gate_we) for (int i = 0; i < 3; i++) m_gate[i] = gate_wdata[i];
      if (tmode_we) for (int i = 0; i < 3; i++) m_mode[i] = tmode_wdata[2*i +: 2];
      if (cfg_we) begin m_src = cfg_src; m_role = cfg_role; end
      if (sel_we) begin m_idx = sel_idx; m_dout = sel_dout; end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int rd;
      for (int i = 0; i < 3; i++)
        chk("R6/R7/R8/R9 tmr_out", tmr_out[i], (m_mode[i] == 0) ? m_lvl[i] : m_evt[i]);
      chk("R11 flag", t2_flag, m_flag);
      chk("R12 dout", dout, m_dout);
      case (m_idx)
        0: rd = m_cnt[0] & 16'hFFFF;
        1: rd = m_cnt[1] & 16'hFFFF;
        2: rd = m_cnt[2] & 16'hFFFF;
        default: rd = (m_cnt[2] >> 16) & 16'hFF;
      endcase
      chk("R2 rdata", dat_rdata, rd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic sel_wr(input logic [1:0] i, input logic [3:0] d);
    @(negedge clk); sel_we = 1; sel_idx = i; sel_dout = d;
    @(negedge clk); sel_we = 0;
  endtask
  task automatic sel_rd();
    @(negedge clk); sel_re = 1;
    @(negedge clk); sel_re = 0;
  endtask
  task automatic dat_wr(input logic [15:0] d);
    @(negedge clk); dat_we = 1; dat_wdata = d;
    @(negedge clk); dat_we = 0;
  endtask
  task automatic mode_wr(input logic [5:0] m);
    @(negedge clk); tmode_we = 1; tmode_wdata = m;
    @(negedge clk); tmode_we = 0;
  endtask
  task automatic gate_wr(input logic [2:0] g);
    @(negedge clk); gate_we = 1; gate_wdata = g;
    @(negedge clk); gate_we = 0;
  endtask
  task automatic cfg_wr(input logic [1:0] s, input logic [1:0] r);
    @(negedge clk); cfg_we = 1; cfg_src = s; cfg_role = r;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic ev_pulse(input bit on_eos, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (on_eos) eos = 1; else eoc = 1;
      @(negedge clk); eos = 0; eoc = 0;
      idle(2);
    end
  endtask
  task automatic wait_out(input int i, output longint t);
    do @(negedge clk); while (!tmr_out[i]);
    t = cyc;
  endtask

  initial begin
    longint ta, tb;
    int r;
    idle(3);
    rst_n = 1;
    idle(1);
    // reset state
    chk("R3 reset out", tmr_out, 0);
    chk("R11 reset flag", t2_flag, 0);
    chk("R12 reset dout", dout, 0);
    chk("R2 reset rdata", dat_rdata, 0);

    sel_wr(0, 4'hA);
    chk("R12 dout write", dout, 4'hA);

    // timer 0 rate generator
    mode_wr(6'b000001);
    dat_wr(16'd3);
    gate_wr(3'b001);
    wait_out(0, ta); wait_out(0, tb);
    chk("R1 R7 period div3", tb - ta, 30);
    dat_wr(16'd5);
    wait_out(0, ta); wait_out(0, tb);
    chk("R7 new divisor at reload", tb - ta, 50);

    // gate off holds count
    gate_wr(3'b000);
    idle(2); r = dat_rdata;
    idle(100);
    chk("R4 gate off holds", dat_rdata, r);

    // software strobe with clamped divisor
    mode_wr(6'b000010);
    chk("R3 mode change idles", dat_rdata, 0);
    gate_wr(3'b001);
    dat_wr(16'd1);
    chk("R5 divisor 1 used as 2", dat_rdata, 2);
    idle(40);
    chk("R8 strobe then idle", dat_rdata, 0);

    // timer 1 terminal count level
    sel_wr(1, 4'h3);
    dat_wr(16'd2);
    gate_wr(3'b011);
    idle(2100);
    chk("R6 level after expiry", tmr_out[1], 1);
    idle(500);
    chk("R6 level held", tmr_out[1], 1);

    // timer 2 wide access
    sel_wr(2, 4'h3); dat_wr(16'h3456);
    sel_wr(3, 4'h3); dat_wr(16'h0012);
    chk("R2 upper half read", dat_rdata, 16'h0012);
    sel_wr(2, 4'h3);
    chk("R2 lower half read", dat_rdata, 16'h3456);

    // timer 2 event counter on eoc
    cfg_wr(2'd2, 2'd1);
    dat_wr(16'd5); sel_wr(3, 4'h3); dat_wr(16'd0); sel_wr(2, 4'h3);
    gate_wr(3'b111);
    ev_pulse(0, 3);
    chk("R10 eoc counted", dat_rdata, 2);
    ev_pulse(0, 2);
    chk("R11 flag set", t2_flag, 1);
    sel_rd();
    chk("R11 flag cleared by read", t2_flag, 0);

    // collision: expiry and clearing read together
    mode_wr(6'b010010);
    @(negedge clk); eoc = 1; sel_re = 1;
    idle(20);
    eoc = 0; sel_re = 0;
    idle(2);

    // hardware strobe on eos
    mode_wr(6'b110010);
    cfg_wr(2'd3, 2'd0);
    gate_wr(3'b011); gate_wr(3'b111);
    chk("R9 gate rise starts", dat_rdata, 5);
    ev_pulse(1, 5);
    chk("R9 strobe sets flag", t2_flag, 1);
    dat_wr(16'd9);
    chk("R9 write only stores", dat_rdata, 0);

    // timer 2 clocked by timer 1 pulses
    mode_wr(6'b010110);
    cfg_wr(2'd1, 2'd1);
    sel_wr(1, 4'h6); dat_wr(16'd2);
    sel_wr(2, 4'h6); dat_wr(16'd2); sel_wr(3, 4'h6); dat_wr(16'd0);
    idle(9000);

    // watchdog on prescaled oscillator
    mode_wr(6'b000110);
    cfg_wr(2'd0, 2'd2);
    sel_rd();
    sel_wr(2, 4'h9); dat_wr(16'd3); sel_wr(3, 4'h9); dat_wr(16'd0);
    for (int k = 0; k < 6; k++) begin idle(1500); sel_rd(); end
    chk("R10 watchdog kicked", t2_flag, 0);
    idle(4000);
    chk("R10 watchdog expired", t2_flag, 1);

    sel_wr(1, 4'h5);
    chk("R12 dout rewritten", dout, 4'h5);

    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule